// File: doc/BRIEF.md
# Line Level Serial Encoder

This block turns one sampled analog level per video line into a short serial word. When the line strobe arrives, it latches the state of the bright-content detector. It then runs a binary-search conversion: it drives a trial code to an external DAC and reads back one comparator bit for each trial. When the conversion ends, it sends the peak flag and then the code, one bit per enabled conversion clock.

The sample it converts was taken at the line strobe, so each word describes the line that has just ended. A full-scale code (all ones) means a fully bright line and zero means a dark line. The flag bit is set when the detector reported content above the half-scale threshold. The analog integrator, the hold capacitor and the comparator sit outside the block. The only link to them is the trial code going out and the comparator bit coming back.

Top module: `sar_line_coder`

## Requirements
- R1: After reset, `ser_valid`, `ser_data`, `dac_code` and `result` are all zero.
- R2: A `hd_strobe` seen while the block is idle latches `peak_lvl` and starts a conversion. At the next clock `dac_code` shows the first trial, which has only the MSB set (binary 100000 for W=6).
- R3: Trials run from the MSB down to the LSB. Each trial sets its bit on top of the bits already kept, and that bit is kept when `cmp_ge` is 1 (input at or above the DAC output). With an ideal comparator, the final code equals the input level.
- R4: Conversion steps and serial shifts advance only on clock edges where `clk_en` is 1. On any other edge, `dac_code` and `ser_data` do not change.
- R5: After the strobe, a conversion takes exactly W enabled cycles. The serial word begins in the cycle that follows the last one.
- R6: The serial word is W+1 bits long. The peak flag comes first, then the code MSB first. `ser_data` moves to the next bit after each enabled edge.
- R7: `ser_valid` is high for exactly W+1 enabled bit periods and falls after the last one.
- R8: `result` takes the value {peak flag, code} when a conversion completes, with the flag in bit W. It holds that value while the word is being shifted out.
- R9: A `hd_strobe` that arrives during a conversion or a shift is ignored. The word in progress is unchanged, and no new conversion starts after it.
- R10: An input at full scale gives code 0x3F, and an input of zero gives code 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hd_strobe | input | 1 | Line sample strobe |
| cmp_ge | input | 1 | Comparator: held level is at or above the DAC output |
| peak_lvl | input | 1 | Bright-content detector output |
| clk_en | input | 1 | Conversion clock enable |
| dac_code | output | W | Trial code driven to the DAC |
| ser_data | output | 1 | Serial word bit |
| ser_valid | output | 1 | High while a serial bit is presented |
| result | output | W+1 | Parallel {peak flag, code} of the last conversion |

## Verification
The first trial code is due one clock after the strobe edge. The first serial bit is due in the cycle after the W-th enabled conversion edge. Each later bit is due one enabled edge after the previous one. The bench drives its inputs on the falling edge and samples 1 ns later. It counts enabled cycles rather than clock cycles, so its expected timing stays correct when `clk_en` is high only one cycle in three. `result` is checked on the first cycle of `ser_valid`, and `ser_valid` is checked to be low on the first cycle after the seventh enabled edge.

// File: rtl/sar_line_coder.sv
`timescale 1ns/1ps
module sar_line_coder #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hd_strobe,
  input  logic         cmp_ge,
  input  logic         peak_lvl,
  input  logic         clk_en,
  output logic [W-1:0] dac_code,
  output logic         ser_data,
  output logic         ser_valid,
  output logic [W:0]   result
);
  localparam int IW = $clog2(W + 1);

  typedef enum logic [1:0] {IDLE, CONV, SHIFT} st_t;

  st_t          st;
  logic [W-1:0] acc;
  logic [IW-1:0] idx;
  logic [W:0]   sreg;
  logic         peak_r;

  wire [W-1:0] mask    = {{(W-1){1'b0}}, 1'b1} << idx;
  wire [W-1:0] acc_nxt = cmp_ge ? (acc | mask) : acc;

  assign dac_code  = (st == CONV) ? (acc | mask) : acc;
  assign ser_valid = (st == SHIFT);
  assign ser_data  = ser_valid & sreg[W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      acc    <= '0;
      idx    <= '0;
      sreg   <= '0;
      peak_r <= 1'b0;
      result <= '0;
    end else begin
      case (st)
        IDLE: if (hd_strobe) begin
          st     <= CONV;
          idx    <= IW'(W - 1);
          acc    <= '0;
          peak_r <= peak_lvl;
        end
        CONV: if (clk_en) begin
          acc <= acc_nxt;
          if (idx == '0) begin
            st     <= SHIFT;
            sreg   <= {peak_r, acc_nxt};
            result <= {peak_r, acc_nxt};
          end else begin
            idx <= idx - 1'b1;
          end
        end
        SHIFT: if (clk_en) begin
          if (idx == IW'(W)) begin
            st  <= IDLE;
            idx <= '0;
          end else begin
            idx  <= idx + 1'b1;
            sreg <= {sreg[W-1:0], 1'b0};
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

module sar_line_coder_chk #(
  parameter int W = 6
) (
  input logic         clk,
  input logic         rst_n,
  input logic         hd_strobe,
  input logic         cmp_ge,
  input logic         peak_lvl,
  input logic         clk_en,
  input logic [W-1:0] dac_code,
  input logic         ser_data,
  input logic         ser_valid,
  input logic [W:0]   result
);
  AST_DAC_IDLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !hd_strobe) |=> $stable(dac_code)); // R4
  AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid && !clk_en) |=> (ser_valid && $stable(ser_data))); // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid && $past(ser_valid)) |-> $stable(result)); // R8
  AST_PEAK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_valid) |-> (ser_data == result[W])); // R6
  AST_CODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_valid) |-> (result[W-1:0] == dac_code)); // R3
  AST_START_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_valid) |-> $past(clk_en)); // R5
  AST_END_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_valid) |-> $past(clk_en)); // R7
  AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_valid |-> !ser_data); // R6
endmodule

bind sar_line_coder sar_line_coder_chk #(.W(W)) chk_i (.*);

// File: tb/sar_line_coder_tb_top.sv
`timescale 1ns/1ps
module sar_line_coder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hd = 1'b0;
  logic       peak_lvl = 1'b0;
  logic       en = 1'b0;
  logic [5:0] lvl = '0;
  logic       cmp_ge;
  logic [5:0] dac_code;
  logic       ser_data;
  logic       ser_valid;
  logic [6:0] result;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;
  assign cmp_ge = (lvl >= dac_code);

  sar_line_coder #(.W(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .hd_strobe(hd), .cmp_ge(cmp_ge),
    .peak_lvl(peak_lvl), .clk_en(en), .dac_code(dac_code),
    .ser_data(ser_data), .ser_valid(ser_valid), .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // inj: 0 none, 1 strobe during conversion, 2 strobe during shift
  task automatic run_word(input int level, input bit pk, input int mode, input int inj);
    logic [6:0] got;
    logic [6:0] exp;
    int nb;
    int steps;
    int k;
    bit first;
    string tag;
    exp = {pk, 6'(level)};
    tag = (level == 0 || level == 63) ? "R10" : "R3";
    @(negedge clk);
    lvl = 6'(level); peak_lvl = pk; hd = 1'b1; en = 1'b0;
    @(negedge clk);
    hd = 1'b0; peak_lvl = ~pk;
    #1;
    chk(dac_code == 6'b100000, "R2", dac_code, 32);
    got = '0; nb = 0; steps = 0; k = 0; first = 1'b1;
    while (nb < 7 && k < 300) begin
      en = (mode == 0) ? 1'b1 : (k % 3 == 2);
      k++;
      if (inj == 1 && steps == 3 && !ser_valid) hd = 1'b1;
      else if (inj == 2 && nb == 2) begin hd = 1'b1; lvl = 6'd10; end
      else hd = 1'b0;
      #1;
      if (ser_valid) begin
        if (first) begin
          chk(steps == 6, "R5", steps, 6);
          chk(result == exp, "R8", result, exp);
          first = 1'b0;
        end
        if (en) begin
          got = {got[5:0], ser_data};
          nb++;
        end
      end else if (en) begin
        steps++;
      end
      @(negedge clk);
    end
    hd = 1'b0; en = 1'b0;
    #1;
    chk(nb == 7, "R7", nb, 7);
    chk(ser_valid == 1'b0, "R7", ser_valid, 0);
    chk(got == exp, (inj != 0) ? "R9" : (mode != 0 ? "R4" : tag), got, exp);
    chk(got[6] == pk, "R6", got[6], pk);
  endtask

  initial begin
    #(1_500_000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(ser_valid == 0, "R1", ser_valid, 0);
    chk(ser_data == 0, "R1", ser_data, 0);
    chk(dac_code == 0, "R1", dac_code, 0);
    chk(result == 0, "R1", result, 0);
    for (int mode = 0; mode < 2; mode++)
      for (int pk = 0; pk < 2; pk++)
        for (int level = 0; level < 64; level++)
          run_word(level, pk[0], mode, 0);
    run_word(37, 1'b0, 0, 1);
    run_word(45, 1'b0, 0, 2);
    run_word(22, 1'b1, 1, 2);
    en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      #1;
      chk(ser_valid == 0, "R9", ser_valid, 0);
      chk(dac_code == 6'd22, "R9", dac_code, 22);
    end
    en = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule